// File: doc/BRIEF.md
# Boot Start-Address and Host Handoff Controller

This block decides where a CPU begins fetching after reset and coordinates the moment an external host hands control over to it. While reset is held, it reads a small set of boot-mode pins. From them it chooses one of two default start addresses: an internal boot ROM or an external memory region behind chip-select 2. The CPU reset-release output goes high on the first clock after reset ends, in every mode.

In host-driven boot modes the start-address register also serves as a mailbox. The ROM bootloader runs first. The host loads its own entry point into the register through a small register bus, then sets a completion bit. One cycle after that bit becomes set, the block sends the CPU a single jump request carrying the address that was written. In the other modes, software never needs to touch the register.

The register bus is a plain control port with no back-pressure. A write is taken on every clock edge at which the write enable is high. Read data is registered and is valid one edge after the address is presented. There is no ready signal, and the bus never stalls.

Top module: `boot_handoff_ctrl`

## Requirements
- R1: Mode pins are encoded as follows. Bit 2 = 1 selects host boot. Bit 0 = 1 with bit 2 = 0 selects the external default. Bit 1 is ignored. The start-address register resets to 0x4200_0000 for the external default and to 0x0010_0000 in every other case, including all host modes.
- R2: `start_addr` always shows the register's bits 31:10, with bits 9:0 forced to zero, whatever value was written.
- R3: `cpu_rst_release` is low while `rst_n` is low. It is high from the first rising edge at which `rst_n` is high, in every mode.
- R4: The mode pins are captured at the last rising edge with `rst_n` low. Later pin changes have no effect until the next reset.
- R5: In a host mode, `jump_req` is a one-cycle pulse. It appears one edge after the completion bit becomes set. `jump_addr` then holds the masked start address that was present at that edge.
- R6: In a non-host mode, `jump_req` stays low, even if the completion bit is written.
- R7: Writing 1 to bit 0 at address 1 sets the completion bit. Writing 0 to it is ignored, and the bit clears only on reset. After the jump, writes to address 0 still update the register, but no further jump follows.
- R8: `reg_rdata` is registered. One edge after `reg_addr` is presented, it shows the full 32-bit register (address 0) or the completion bit in bit 0 with zeros above it (address 1). The value shown is the one held before that edge.
- R9: At any other address, reads return zero and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 3 | Boot-mode pins, captured during reset |
| reg_addr | input | 2 | Register bus address |
| reg_wr | input | 1 | Register bus write enable |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Registered read data |
| start_addr | output | 32 | Current start address, bits 9:0 zero |
| cpu_rst_release | output | 1 | CPU allowed out of reset |
| jump_req | output | 1 | One-cycle jump request to the CPU |
| jump_addr | output | 32 | Target of the jump request |

## Verification
Each result has a fixed latency:

- `start_addr` follows an address write one edge later.
- `reg_rdata` reflects the address presented one edge earlier.
- `cpu_rst_release` rises at the first edge after reset.
- `jump_req` fires two edges after the completion write: one edge to set the bit and one to issue the request.

The bench's reference model advances at each rising edge with those same latencies. It is compared with the outputs at each falling edge, where every output has already settled for the cycle.

// File: rtl/boot_handoff_pkg.sv
package boot_handoff_pkg;

  localparam logic [31:0] ROM_START = 32'h0010_0000;
  localparam logic [31:0] EXT_START = 32'h4200_0000;

  typedef struct packed {
    logic host;
    logic ext;
  } boot_cfg_t;

  function automatic boot_cfg_t decode_mode(input logic [2:0] pins);
    boot_cfg_t c;
    c.host = pins[2];
    c.ext  = ~pins[2] & pins[0];
    return c;
  endfunction

endpackage

// File: rtl/boot_cfg_latch.sv
module boot_cfg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic host_pin,
  output logic host_q,
  output logic release_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_q    <= host_pin;
      release_q <= 1'b0;
    end else begin
      release_q <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_regs.sv
module boot_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] reset_value,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] addr_word,
  output logic              done_flag
);
  localparam logic [ADDR_W-1:0] SEL_START = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SEL_DONE  = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_word <= reset_value;
      done_flag <= 1'b0;
      rdata     <= '0;
    end else begin
      case (addr)
        SEL_START: rdata <= addr_word;
        SEL_DONE:  rdata <= {{(DATA_W-1){1'b0}}, done_flag};
        default:   rdata <= '0;
      endcase
      if (wr_en && addr == SEL_START) addr_word <= wdata;
      if (wr_en && addr == SEL_DONE && wdata[0]) done_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_jump.sv
module boot_jump #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host,
  input  logic              done_flag,
  input  logic [DATA_W-1:0] target,
  output logic              jump_req,
  output logic [DATA_W-1:0] jump_addr
);
  logic fired_q;
  logic fire;

  assign fire = host & done_flag & ~fired_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fired_q   <= 1'b0;
      jump_req  <= 1'b0;
      jump_addr <= '0;
    end else begin
      jump_req <= fire;
      if (fire) begin
        fired_q   <= 1'b1;
        jump_addr <= target;
      end
    end
  end
endmodule

// File: rtl/boot_handoff_ctrl.sv
module boot_handoff_ctrl
  import boot_handoff_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int MODE_W    = 3,
  parameter int IGNORED_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] boot_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] start_addr,
  output logic              cpu_rst_release,
  output logic              jump_req,
  output logic [DATA_W-1:0] jump_addr
);
  localparam int KEEP_W = DATA_W - IGNORED_W;

  boot_cfg_t         pin_cfg;
  logic [DATA_W-1:0] reset_value;
  logic [DATA_W-1:0] addr_word;
  logic              done_flag;
  logic              host_q;
  logic              unused_mode_bit;

  assign pin_cfg         = decode_mode(boot_mode[2:0]);
  assign unused_mode_bit = boot_mode[1];
  assign reset_value     = pin_cfg.ext ? DATA_W'(EXT_START) : DATA_W'(ROM_START);
  assign start_addr      = {addr_word[DATA_W-1:IGNORED_W], {IGNORED_W{1'b0}}};

  boot_cfg_latch u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_pin  (pin_cfg.host),
    .host_q    (host_q),
    .release_q (cpu_rst_release)
  );

  boot_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_value (reset_value),
    .wr_en       (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .addr_word   (addr_word),
    .done_flag   (done_flag)
  );

  boot_jump #(.DATA_W(DATA_W)) u_jump (
    .clk       (clk),
    .rst_n     (rst_n),
    .host      (host_q),
    .done_flag (done_flag),
    .target    (start_addr),
    .jump_req  (jump_req),
    .jump_addr (jump_addr)
  );

  if (KEEP_W <= 0) begin : g_bad_width
    initial $error("IGNORED_W must be below DATA_W");
  end
endmodule

// File: rtl/boot_handoff_chk.sv
module boot_handoff_chk #(
  parameter int DATA_W    = 32,
  parameter int IGNORED_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_q,
  input logic              done_flag,
  input logic              cpu_rst_release,
  input logic              jump_req,
  input logic [DATA_W-1:0] jump_addr,
  input logic [DATA_W-1:0] start_addr
);
  // R3: release never drops back while out of reset
  a_r3_release_held: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_release |=> cpu_rst_release);

  // R4: latched mode stays put between resets
  a_r4_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(host_q));

  // R5: jump request lasts one cycle only
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |=> !jump_req);

  // R5: jump target has its low bits cleared
  a_r5_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> (jump_addr[IGNORED_W-1:0] == '0));

  // R6: no jump outside host modes
  a_r6_no_jump_nonhost: assert property (@(posedge clk) disable iff (!rst_n)
    !host_q |-> !jump_req);

  // R5: a jump only follows a set completion bit
  a_r5_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> done_flag);

  // R7: completion bit is sticky
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |=> done_flag);

  // R2: presented start address never carries low bits
  a_r2_start_masked: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_release |-> (start_addr[IGNORED_W-1:0] == '0));
endmodule

bind boot_handoff_ctrl boot_handoff_chk #(.DATA_W(DATA_W), .IGNORED_W(IGNORED_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .host_q          (host_q),
  .done_flag       (done_flag),
  .cpu_rst_release (cpu_rst_release),
  .jump_req        (jump_req),
  .jump_addr       (jump_addr),
  .start_addr      (start_addr)
);

// File: tb/boot_handoff_ctrl_test.sv
module boot_handoff_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROM_A = 32'h0010_0000;
  localparam logic [31:0] EXT_A = 32'h4200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  boot_mode = 3'b000;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata, start_addr, jump_addr;
  logic        cpu_rst_release, jump_req;

  int total = 0;
  int bad = 0;

  boot_handoff_ctrl uut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .start_addr(start_addr), .cpu_rst_release(cpu_rst_release),
    .jump_req(jump_req), .jump_addr(jump_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit          m_ok = 0;
  bit          m_host, m_done, m_fired, m_jump, m_rel;
  logic [31:0] m_addr, m_jaddr, m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_host  = boot_mode[2];
      m_addr  = (!boot_mode[2] && boot_mode[0]) ? EXT_A : ROM_A;
      m_done  = 0; m_fired = 0; m_jump = 0; m_rel = 0;
      m_jaddr = 0; m_rd = 0;
    end else begin
      if (reg_addr == 2'd0)      m_rd = m_addr;
      else if (reg_addr == 2'd1) m_rd = {31'b0, m_done};
      else                       m_rd = 32'h0;
      m_rel  = 1;
      m_jump = 0;
      if (m_host && m_done && !m_fired) begin
        m_jump = 1; m_fired = 1; m_jaddr = m_addr & ~32'h3FF;
      end
      if (reg_wr && reg_addr == 2'd0) m_addr = reg_wdata;
      if (reg_wr && reg_addr == 2'd1 && reg_wdata[0]) m_done = 1;
    end
    m_ok = 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_ok) begin
      check("R8 rdata", reg_rdata, m_rd);
      check("R1/R2 start_addr", start_addr, m_addr & ~32'h3FF);
      check("R3 release", {31'b0, cpu_rst_release}, {31'b0, m_rel});
      check(m_host ? "R5 jump_req" : "R6 jump_req", {31'b0, jump_req}, {31'b0, m_jump});
      check("R5 jump_addr", jump_addr, m_jaddr);
    end
  end

  task automatic do_reset(input logic [2:0] mode);
    @(negedge clk);
    rst_n = 0; boot_mode = mode;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // non-host, external default; mode bit 1 set to show it is ignored (R1)
    do_reset(3'b011);
    idle(2);
    check("R1 ext default", start_addr, EXT_A);
    boot_mode = 3'b100;               // R4: pin change after reset
    idle(3);
    check("R4 pins ignored", start_addr, EXT_A);
    wr(2'd1, 32'h1);                  // R6: completion in non-host mode
    idle(4);
    check("R6 no jump", {31'b0, jump_req}, 32'h0);

    // host mode
    do_reset(3'b101);
    idle(1);
    check("R1 host rom default", start_addr, ROM_A);
    wr(2'd0, 32'h8000_03FF);
    reg_addr = 2'd0;
    idle(2);
    check("R8 full readback", reg_rdata, 32'h8000_03FF);
    check("R2 masked", start_addr, 32'h8000_0000);
    wr(2'd1, 32'h1);
    idle(4);
    wr(2'd0, 32'h1234_5678);          // R7: later write, no new jump
    wr(2'd1, 32'h0);                  // R7: clear attempt ignored
    reg_addr = 2'd1;
    idle(2);
    check("R7 done sticky", reg_rdata, 32'h1);
    check("R7 jump held", jump_addr, 32'h8000_0000);

    // host mode, other address space
    do_reset(3'b110);
    wr(2'd2, 32'hFFFF_FFFF);          // R9
    reg_addr = 2'd3;
    idle(2);
    check("R9 unmapped read", reg_rdata, 32'h0);
    check("R9 unmapped write", start_addr, ROM_A);
    wr(2'd0, 32'h0ABC_DC00);
    wr(2'd1, 32'h3);
    idle(4);

    // non-host, ROM default
    do_reset(3'b000);
    idle(3);
    check("R1 rom default", start_addr, ROM_A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule